// File: doc/BRIEF.md
# Synchronizable Reference and Main Dividers

This block holds the two programmable counters that sit in front of a phase/frequency detector in a frequency synthesizer. One divides the reference tick stream and the other divides the RF-derived tick stream, each by its own ratio, so that both reach a common comparison rate. Each divider emits a one-cycle pulse at the end of every division period. The ratio values come from latch registers that a separate programming interface writes. The dividers re-read those latches only at their terminal count, so a rewrite can never tear a period in progress.

Both counters run in one clock domain. The rising edges of each input clock arrive as a one-cycle tick strobe. The dividers stop when either a hardware power-down pin or a software power-down bit is high. While stopped, each counter is held at its reload value. Because of this, both dividers leave power-down on the same cycle with a full count loaded. Their first output pulses then fall exactly one programmed period later, with no random phase offset between them.

Top module: `sync_ratio_dividers`

## Requirements
- R1: The reference ratio is a 12-bit unsigned binary value (2 to 4095 usable). With its tick held high, `ref_pulse_o` is high once every N clock cycles, where N is the effective reference ratio.
- R2: The main ratio is a 17-bit unsigned binary value supporting 512 to 131071 inclusive. With its tick held high, `main_pulse_o` is high once every N clock cycles.
- R3: A counter advances only on cycles where its tick input is high. With ticks on every second cycle, the output period doubles in clock cycles.
- R4: A reference ratio below 2 is treated as 2, and a main ratio below 512 is treated as 512.
- R5: Power-down is active when `pd_pin_i` OR `pd_soft_i` is 1. While it is active, both outputs stay low and both counters are held at their reload values.
- R6: After power-down clears, each divider's first pulse appears exactly its ratio in ticks after the first clock edge with power-down low. Dividers with equal periods therefore pulse in the same cycle.
- R7: A ratio change takes effect only at terminal count. The period in progress completes at the old ratio.
- R8: Every output pulse is exactly one clock cycle wide.
- R9: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_pin_i | input | 1 | Hardware power-down, active high |
| pd_soft_i | input | 1 | Software power-down bit, active high |
| ref_tick_i | input | 1 | Reference count strobe |
| main_tick_i | input | 1 | Main count strobe |
| ref_ratio_i | input | 12 | Latched reference divide ratio |
| main_ratio_i | input | 17 | Latched main divide ratio |
| ref_pulse_o | output | 1 | Reference divider output pulse |
| main_pulse_o | output | 1 | Main divider output pulse |

## Verification
The assertions take three things for granted about the inputs. Ratio latches change only between clock edges. Tick strobes are plain one-cycle qualifiers in the block's own clock. Reset is held for at least one edge before any property is evaluated. The stimulus meets these conditions in the following way. Every input is driven on the falling clock edge, and ratios are rewritten only while a divider is mid-period or stopped, never in the same cycle as a wake-up. The reference tick pattern is generated relative to the wake-up cycle, which makes the expected pulse cycles exact.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;

  // Effective divide ratio: requests under the floor run at the floor.
  function automatic logic [31:0] eff_ratio(input logic [31:0] req,
                                            input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Value loaded into a down-counter that reaches zero after ratio ticks.
  function automatic logic [31:0] reload_of(input logic [31:0] ratio);
    return ratio - 32'd1;
  endfunction

endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic soft_i,
  output logic hold_o,
  output logic wake_o
);

  logic hold_q;

  assign hold_o = pin_i | soft_i;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b1;
    else        hold_q <= hold_o;
  end

  // First cycle in which counting resumes.
  assign wake_o = hold_q & ~hold_o;

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider
  import sync_div_pkg::*;
#(
  parameter int W         = 12,
  parameter int MIN_RATIO = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] load_o,
  output logic [W-1:0] active_o,
  output logic         tc_o
);

  localparam logic [31:0] FLOOR = 32'(MIN_RATIO);

  logic [W-1:0] eff;

  assign eff    = W'(eff_ratio(32'(ratio_i), FLOOR));
  assign load_o = W'(reload_of(32'(eff)));
  assign tc_o   = tick_i & ~hold_i & (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_i) begin
      cnt_o    <= load_o;
      active_o <= eff;
      pulse_o  <= 1'b0;
    end else begin
      pulse_o <= tc_o;
      if (tc_o) begin
        cnt_o    <= load_o;
        active_o <= eff;
      end else if (tick_i) begin
        cnt_o <= cnt_o - W'(1);
      end
    end
  end

endmodule

// File: rtl/sync_ratio_dividers.sv
module sync_ratio_dividers #(
  parameter int REF_W    = 12,
  parameter int MAIN_W   = 17,
  parameter int REF_MIN  = 2,
  parameter int MAIN_MIN = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_pin_i,
  input  logic              pd_soft_i,
  input  logic              ref_tick_i,
  input  logic              main_tick_i,
  input  logic [REF_W-1:0]  ref_ratio_i,
  input  logic [MAIN_W-1:0] main_ratio_i,
  output logic              ref_pulse_o,
  output logic              main_pulse_o
);

  logic              pd_active;
  logic              wake_evt;
  logic [REF_W-1:0]  ref_cnt, ref_load, ref_active;
  logic [MAIN_W-1:0] main_cnt, main_load, main_active;
  logic              ref_tc, main_tc;

  pd_ctrl pd_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pd_pin_i),
    .soft_i (pd_soft_i),
    .hold_o (pd_active),
    .wake_o (wake_evt)
  );

  ratio_divider #(.W(REF_W), .MIN_RATIO(REF_MIN)) ref_div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (pd_active),
    .tick_i   (ref_tick_i),
    .ratio_i  (ref_ratio_i),
    .pulse_o  (ref_pulse_o),
    .cnt_o    (ref_cnt),
    .load_o   (ref_load),
    .active_o (ref_active),
    .tc_o     (ref_tc)
  );

  ratio_divider #(.W(MAIN_W), .MIN_RATIO(MAIN_MIN)) main_div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (pd_active),
    .tick_i   (main_tick_i),
    .ratio_i  (main_ratio_i),
    .pulse_o  (main_pulse_o),
    .cnt_o    (main_cnt),
    .load_o   (main_load),
    .active_o (main_active),
    .tc_o     (main_tc)
  );

endmodule

// File: rtl/sync_ratio_dividers_chk.sv
module sync_ratio_dividers_chk #(
  parameter int REF_W    = 12,
  parameter int MAIN_W   = 17,
  parameter int MAIN_MIN = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_active,
  input logic              wake_evt,
  input logic              ref_tick,
  input logic              ref_pulse,
  input logic              main_pulse,
  input logic [REF_W-1:0]  ref_cnt,
  input logic [REF_W-1:0]  ref_load,
  input logic [MAIN_W-1:0] main_cnt,
  input logic [MAIN_W-1:0] main_load,
  input logic [MAIN_W-1:0] main_active,
  input logic              main_tc
);

  // R5
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> (!ref_pulse && !main_pulse));

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> (ref_cnt == $past(ref_load) && main_cnt == $past(main_load)));

  // R6
  wake_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> (ref_cnt == $past(ref_load) && main_cnt == $past(main_load)));

  // R3
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_active && !ref_tick) |=> $stable(ref_cnt));

  // R8
  ref_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R8
  main_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |=> !main_pulse);

  // R7
  ratio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_active && !main_tc) |=> $stable(main_active));

  // R4
  main_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_tc |=> (main_active >= MAIN_W'(MAIN_MIN)));

endmodule

bind sync_ratio_dividers sync_ratio_dividers_chk #(
  .REF_W(REF_W), .MAIN_W(MAIN_W), .MAIN_MIN(MAIN_MIN)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pd_active   (pd_active),
  .wake_evt    (wake_evt),
  .ref_tick    (ref_tick_i),
  .ref_pulse   (ref_pulse_o),
  .main_pulse  (main_pulse_o),
  .ref_cnt     (ref_cnt),
  .ref_load    (ref_load),
  .main_cnt    (main_cnt),
  .main_load   (main_load),
  .main_active (main_active),
  .main_tc     (main_tc)
);

// File: tb/sync_ratio_dividers_tb_top.sv
module sync_ratio_dividers_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_pin = 1'b1;
  logic        pd_soft = 1'b0;
  logic        ref_tick = 1'b1;
  logic        main_tick = 1'b1;
  logic [11:0] ref_ratio = 12'd10;
  logic [16:0] main_ratio = 17'd512;
  logic        ref_pulse, main_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ratio_dividers dut_i (
    .clk(clk), .rst_n(rst_n), .pd_pin_i(pd_pin), .pd_soft_i(pd_soft),
    .ref_tick_i(ref_tick), .main_tick_i(main_tick),
    .ref_ratio_i(ref_ratio), .main_ratio_i(main_ratio),
    .ref_pulse_o(ref_pulse), .main_pulse_o(main_pulse)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0, errors = 0;
  int    ref_q[$], main_q[$];
  string ref_t[$], main_t[$];
  string cur_tag = "R5";
  int    ref_seen = 0, main_seen = 0, last_ref = -1, last_main = -1;
  logic  prev_ref = 1'b0, prev_main = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic go_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Scoreboard monitor: compares each pulse against the queued cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ref_pulse) begin
        ref_seen++; last_ref = cyc;
        check(!prev_ref, "R8", "ref pulse width", 2, 1);
        if (ref_q.size() == 0) check(1'b0, cur_tag, "unexpected ref pulse", cyc, -1);
        else begin
          check(ref_q[0] == cyc, ref_t[0], "ref pulse cycle", cyc, ref_q[0]);
          void'(ref_q.pop_front()); void'(ref_t.pop_front());
        end
      end else if (ref_q.size() > 0 && ref_q[0] < cyc) begin
        check(1'b0, ref_t[0], "missing ref pulse", cyc, ref_q[0]);
        void'(ref_q.pop_front()); void'(ref_t.pop_front());
      end
      if (main_pulse) begin
        main_seen++; last_main = cyc;
        check(!prev_main, "R8", "main pulse width", 2, 1);
        if (main_q.size() == 0) check(1'b0, cur_tag, "unexpected main pulse", cyc, -1);
        else begin
          check(main_q[0] == cyc, main_t[0], "main pulse cycle", cyc, main_q[0]);
          void'(main_q.pop_front()); void'(main_t.pop_front());
        end
      end else if (main_q.size() > 0 && main_q[0] < cyc) begin
        check(1'b0, main_t[0], "missing main pulse", cyc, main_q[0]);
        void'(main_q.pop_front()); void'(main_t.pop_front());
      end
    end
    prev_ref  = ref_pulse;
    prev_main = main_pulse;
  end

  initial begin
    int k, sr, sm;
    repeat (4) @(negedge clk);
    // R9: outputs low under reset
    check(!ref_pulse && !main_pulse, "R9", "pulses in reset", int'(ref_pulse) + int'(main_pulse), 0);
    rst_n = 1'b1;
    go_to(cyc + 50);
    // R5: pin power-down keeps both quiet
    check(ref_seen == 0 && main_seen == 0, "R5", "pulses under pin power-down", ref_seen + main_seen, 0);

    // Run, with mid-period ratio changes (R1, R2, R7)
    k = cyc; pd_pin = 1'b0; cur_tag = "R1";
    ref_q.push_back(k + 10); ref_t.push_back("R1");
    ref_q.push_back(k + 20); ref_t.push_back("R7");
    for (int j = 0; j <= 83; j++) begin ref_q.push_back(k + 40 + 20*j); ref_t.push_back("R7"); end
    main_q.push_back(k + 512);  main_t.push_back("R2");
    main_q.push_back(k + 1024); main_t.push_back("R7");
    main_q.push_back(k + 1624); main_t.push_back("R7");
    go_to(k + 15);  ref_ratio = 12'd20;
    go_to(k + 700); main_ratio = 17'd600;
    go_to(k + 1700); pd_soft = 1'b1; cur_tag = "R5";
    go_to(k + 1701);
    sr = ref_seen; sm = main_seen;
    ref_ratio = 12'd600; main_ratio = 17'd600;
    go_to(cyc + 20); pd_soft = 1'b0; pd_pin = 1'b1;
    go_to(cyc + 20);
    // R5: either source alone holds the dividers
    check(ref_seen == sr && main_seen == sm, "R5", "pulses under soft/pin power-down",
          ref_seen + main_seen - sr - sm, 0);

    // Aligned wake-up (R6)
    k = cyc; pd_pin = 1'b0; cur_tag = "R6";
    for (int j = 1; j <= 3; j++) begin
      ref_q.push_back(k + 600*j);  ref_t.push_back("R6");
      main_q.push_back(k + 600*j); main_t.push_back("R6");
    end
    go_to(k + 601);
    check(last_ref == last_main, "R6", "ref vs main first pulse", last_ref, last_main);
    check(last_ref == k + 600, "R6", "first pulse after wake", last_ref, k + 600);
    go_to(k + 1800); pd_pin = 1'b1; cur_tag = "R5";

    // Clamping and tick gating (R3, R4)
    ref_ratio = 12'd1; main_ratio = 17'd100;
    go_to(cyc + 5);
    k = cyc; pd_pin = 1'b0; ref_tick = 1'b0; cur_tag = "R3";
    for (int j = 1; j <= 275; j++) begin ref_q.push_back(k + 4*j); ref_t.push_back("R3"); end
    main_q.push_back(k + 512);  main_t.push_back("R4");
    main_q.push_back(k + 1024); main_t.push_back("R4");
    while (cyc < k + 1100) begin
      @(negedge clk);
      ref_tick = ((cyc + 1 - k) % 2 == 0);
    end
    pd_pin = 1'b1; ref_tick = 1'b1; cur_tag = "R5";

    // Upper range limits (R1, R2)
    ref_ratio = 12'd4095; main_ratio = 17'd131071;
    go_to(cyc + 5);
    k = cyc; pd_pin = 1'b0; cur_tag = "R1";
    for (int j = 1; j <= 32; j++) begin ref_q.push_back(k + 4095*j); ref_t.push_back("R1"); end
    main_q.push_back(k + 131071); main_t.push_back("R2");
    go_to(k + 131072); pd_pin = 1'b1; cur_tag = "R5";
    go_to(cyc + 10);
    check(ref_q.size() == 0, "R1", "ref expectations left", ref_q.size(), 0);
    check(main_q.size() == 0, "R2", "main expectations left", main_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule